// File: doc/BRIEF.md
# Fault Status and Alert Controller

This block keeps the fault picture of a power stage for a management bus target. One-cycle event pulses from the fault detectors set sticky bits in six per-category status registers (output voltage, output current, input, temperature, communication, vendor-specific). From those registers, plus a busy flag, an output-off indication and the power-good input, the block builds an 8-bit summary byte and a 16-bit summary word for the bus engine to return on reads.

An active-low alert line tells the host that something new has gone wrong. Each category has its own mask byte. The bus engine loads a mask with a write strobe that carries the category's command code and the mask value. The alert is a latch: an event on an unmasked bit, or a bus-message timeout, sets it. It is released only by a clear-faults strobe or by the bus engine reporting that this target won an alert-response-address read. A latched-off flag records that the output was shut down by a fault. It survives the clear-faults strobe and is removed only by reset.

All control and status pins are plain level or pulse signals. There is no streamed data path, so the block has no valid/ready handshake and never applies back-pressure.

Top module: `fault_alert_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `evt_i` sets bit i of `stat_o` at the next clock edge. The bit then stays set until a clear-faults strobe. Category c occupies bits 8c+7..8c, with c = 0 output voltage, 1 output current, 2 input, 3 temperature, 4 communication, 5 vendor-specific.
- R2: `clr_i` zeroes every status register and the busy flag at the next edge. If an event arrives in the same cycle as the clear, that event's bit is set afterwards.
- R3: `status_byte_o[6]` (off) is 1 whenever `out_en_i` is 0 or the latched-off flag is set. A `latch_off_evt_i` pulse sets that flag, and `clr_i` does not clear it.
- R4: `status_byte_o` holds, from bit 7 down: sticky busy, off, output-voltage bit 7 (overvoltage), output-current bit 7 (overcurrent), input bit 4 (undervoltage), OR of temperature, OR of communication, and 0.
- R5: `status_word_o[7:0]` equals the status byte. Its high byte holds, from bit 15 down: OR of output voltage, OR of output current, OR of input, OR of vendor-specific, and NOT `pgood_i`. Bits 10..8 are 0.
- R6: An event on a bit whose mask bit is 0 drives `alert_n_o` low at the next edge.
- R7: An event on a masked bit still sets the status bit but does not assert the alert.
- R8: A mask write (`mask_wr_i`) loads `mask_val_i` into the mask of the category whose code is on `mask_sel_i`: 0x7A, 0x7B, 0x7C, 0x7D and 0x7E for categories 0 to 4, and 0x80 for category 5. A write with any other code changes no mask.
- R9: `clr_i` or `ara_won_i` releases the alert at the next edge. `ara_won_i` leaves the status bits unchanged. An unmasked event in the same cycle as a release keeps the alert asserted.
- R10: A `tmo_evt_i` pulse asserts the alert at the next edge regardless of masks, and it sets communication bit 1 (bit 33 of `stat_o`).
- R11: After reset all status bits, the busy flag and the latched-off flag are 0, every mask is 0, and `alert_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 48 | Fault event pulses, one per status bit |
| busy_evt_i | input | 1 | Busy fault event pulse |
| tmo_evt_i | input | 1 | Bus message timeout pulse |
| latch_off_evt_i | input | 1 | Output latched off by a fault |
| out_en_i | input | 1 | Output is enabled and powered |
| pgood_i | input | 1 | Power good |
| clr_i | input | 1 | Clear-faults strobe |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 8 | Command code of the target status register |
| mask_val_i | input | 8 | Mask byte |
| ara_won_i | input | 1 | Alert-response-address read won by this target |
| stat_o | output | 48 | Per-category status registers |
| status_byte_o | output | 8 | Summary byte |
| status_word_o | output | 16 | Summary word |
| alert_n_o | output | 1 | Active-low alert |

## Verification
Two pairs of functions can act in the same cycle: a fault event against a clear-faults strobe, and a fault event against an alert release. The bench provokes both by pulsing an event bit on the same clock as `clr_i` or `ara_won_i`. After the edge it judges that the event's status bit is set, that all other bits are cleared, and that `alert_n_o` stays low. It also drives a release with no concurrent event and checks that the alert goes high while the sticky bits that an ARA does not touch remain set.

// File: rtl/fsa_pkg.sv
`timescale 1ns/1ps
package fsa_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned NCAT   = 6;
  localparam int unsigned FLAT_W = NCAT * STAT_W;

  localparam int unsigned CAT_VOUT  = 0;
  localparam int unsigned CAT_IOUT  = 1;
  localparam int unsigned CAT_INPUT = 2;
  localparam int unsigned CAT_TEMP  = 3;
  localparam int unsigned CAT_CML   = 4;
  localparam int unsigned CAT_MFR   = 5;

  localparam int unsigned OV_BIT  = 7;
  localparam int unsigned OC_BIT  = 7;
  localparam int unsigned UV_BIT  = 4;
  localparam int unsigned TMO_BIT = 1;

  localparam logic [7:0] CODE_FIRST = 8'h7A;
  localparam logic [7:0] CODE_MFR   = 8'h80;

  function automatic logic [7:0] cat_code(input int unsigned idx);
    if (idx == CAT_MFR) return CODE_MFR;
    return CODE_FIRST + 8'(idx);
  endfunction
endpackage

// File: rtl/fsa_status_bank.sv
`timescale 1ns/1ps
module fsa_status_bank #(
  parameter int unsigned NCAT = fsa_pkg::NCAT,
  parameter int unsigned W    = fsa_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAT*W-1:0] set_i,
  input  logic              clr_i,
  output logic [NCAT*W-1:0] stat_o
);
  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    logic [W-1:0] reg_q;
    always_ff @(posedge clk) begin
      if (!rst_n)     reg_q <= '0;
      else if (clr_i) reg_q <= set_i[c*W +: W];
      else            reg_q <= reg_q | set_i[c*W +: W];
    end
    assign stat_o[c*W +: W] = reg_q;
  end
endmodule

// File: rtl/fsa_mask_bank.sv
`timescale 1ns/1ps
module fsa_mask_bank #(
  parameter int unsigned NCAT = fsa_pkg::NCAT,
  parameter int unsigned W    = fsa_pkg::STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [7:0]        sel_i,
  input  logic [W-1:0]      val_i,
  output logic [NCAT*W-1:0] mask_o
);
  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    logic [W-1:0] mask_q;
    logic         hit;
    assign hit = wr_i && (sel_i == fsa_pkg::cat_code(c));
    always_ff @(posedge clk) begin
      if (!rst_n)   mask_q <= '0;
      else if (hit) mask_q <= val_i;
    end
    assign mask_o[c*W +: W] = mask_q;
  end
endmodule

// File: rtl/fsa_alert_latch.sv
`timescale 1ns/1ps
module fsa_alert_latch #(
  parameter int unsigned FLAT_W = fsa_pkg::FLAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] set_i,
  input  logic [FLAT_W-1:0] mask_i,
  input  logic              force_i,
  input  logic              release_i,
  output logic              alert_n_o
);
  logic raise;
  logic active_q;

  assign raise = (|(set_i & ~mask_i)) | force_i;

  always_ff @(posedge clk) begin
    if (!rst_n)         active_q <= 1'b0;
    else if (raise)     active_q <= 1'b1;
    else if (release_i) active_q <= 1'b0;
  end

  assign alert_n_o = ~active_q;
endmodule

// File: rtl/fsa_summary.sv
`timescale 1ns/1ps
module fsa_summary #(
  parameter int unsigned NCAT = fsa_pkg::NCAT,
  parameter int unsigned W    = fsa_pkg::STAT_W
) (
  input  logic [NCAT*W-1:0] stat_i,
  input  logic              busy_i,
  input  logic              off_i,
  input  logic              pgood_i,
  output logic [7:0]        byte_o,
  output logic [15:0]       word_o
);
  import fsa_pkg::*;

  logic [NCAT-1:0] any_set;
  for (genvar c = 0; c < NCAT; c++) begin : g_or
    assign any_set[c] = |stat_i[c*W +: W];
  end

  logic [7:0] hi;

  always_comb begin
    byte_o    = '0;
    byte_o[7] = busy_i;
    byte_o[6] = off_i;
    byte_o[5] = stat_i[CAT_VOUT*W + OV_BIT];
    byte_o[4] = stat_i[CAT_IOUT*W + OC_BIT];
    byte_o[3] = stat_i[CAT_INPUT*W + UV_BIT];
    byte_o[2] = any_set[CAT_TEMP];
    byte_o[1] = any_set[CAT_CML];

    hi    = '0;
    hi[7] = any_set[CAT_VOUT];
    hi[6] = any_set[CAT_IOUT];
    hi[5] = any_set[CAT_INPUT];
    hi[4] = any_set[CAT_MFR];
    hi[3] = ~pgood_i;

    word_o = {hi, byte_o};
  end
endmodule

// File: rtl/fault_alert_ctrl.sv
`timescale 1ns/1ps
module fault_alert_ctrl #(
  parameter int unsigned NCAT   = fsa_pkg::NCAT,
  parameter int unsigned W      = fsa_pkg::STAT_W,
  localparam int unsigned FLAT_W = NCAT * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAT_W-1:0] evt_i,
  input  logic              busy_evt_i,
  input  logic              tmo_evt_i,
  input  logic              latch_off_evt_i,
  input  logic              out_en_i,
  input  logic              pgood_i,
  input  logic              clr_i,
  input  logic              mask_wr_i,
  input  logic [7:0]        mask_sel_i,
  input  logic [W-1:0]      mask_val_i,
  input  logic              ara_won_i,
  output logic [FLAT_W-1:0] stat_o,
  output logic [7:0]        status_byte_o,
  output logic [15:0]       status_word_o,
  output logic              alert_n_o
);
  import fsa_pkg::*;

  localparam int unsigned TMO_POS = CAT_CML * W + TMO_BIT;

  logic [FLAT_W-1:0] set_vec;
  logic [FLAT_W-1:0] mask_flat;
  logic              busy_q;
  logic              latched_off_q;
  logic              off_bit;

  always_comb begin
    set_vec          = evt_i;
    set_vec[TMO_POS] = evt_i[TMO_POS] | tmo_evt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (busy_evt_i) busy_q <= 1'b1;
    else if (clr_i)      busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               latched_off_q <= 1'b0;
    else if (latch_off_evt_i) latched_off_q <= 1'b1;
  end

  assign off_bit = ~out_en_i | latched_off_q;

  fsa_status_bank #(.NCAT(NCAT), .W(W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_i),
    .stat_o (stat_o)
  );

  fsa_mask_bank #(.NCAT(NCAT), .W(W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (mask_wr_i),
    .sel_i  (mask_sel_i),
    .val_i  (mask_val_i),
    .mask_o (mask_flat)
  );

  fsa_alert_latch #(.FLAT_W(FLAT_W)) u_alert (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .mask_i    (mask_flat),
    .force_i   (tmo_evt_i),
    .release_i (clr_i | ara_won_i),
    .alert_n_o (alert_n_o)
  );

  fsa_summary #(.NCAT(NCAT), .W(W)) u_sum (
    .stat_i  (stat_o),
    .busy_i  (busy_q),
    .off_i   (off_bit),
    .pgood_i (pgood_i),
    .byte_o  (status_byte_o),
    .word_o  (status_word_o)
  );
endmodule

// File: rtl/fault_alert_ctrl_chk.sv
`timescale 1ns/1ps
module fault_alert_ctrl_chk #(
  parameter int unsigned FLAT_W = fsa_pkg::FLAT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FLAT_W-1:0] evt_i,
  input logic              tmo_evt_i,
  input logic              clr_i,
  input logic              ara_won_i,
  input logic              out_en_i,
  input logic [FLAT_W-1:0] stat_o,
  input logic [7:0]        status_byte_o,
  input logic [15:0]       status_word_o,
  input logic              alert_n_o
);
  import fsa_pkg::*;

  logic [FLAT_W-1:0] setv;
  always_comb begin
    setv = evt_i;
    setv[CAT_CML*STAT_W + TMO_BIT] = evt_i[CAT_CML*STAT_W + TMO_BIT] | tmo_evt_i;
  end

  assert_bits_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|setv) |=> ((stat_o & $past(setv)) == $past(setv)));

  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((stat_o & ~$past(setv)) == '0));

  assert_off_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_i |-> status_byte_o[6]);

  assert_word_low_is_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_word_o[7:0] == status_byte_o);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i || ara_won_i) && !(|evt_i) && !tmo_evt_i) |=> alert_n_o);

  assert_timeout_alert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt_i |=> !alert_n_o);
endmodule

bind fault_alert_ctrl fault_alert_ctrl_chk #(.FLAT_W(FLAT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_i         (evt_i),
  .tmo_evt_i     (tmo_evt_i),
  .clr_i         (clr_i),
  .ara_won_i     (ara_won_i),
  .out_en_i      (out_en_i),
  .stat_o        (stat_o),
  .status_byte_o (status_byte_o),
  .status_word_o (status_word_o),
  .alert_n_o     (alert_n_o)
);

// File: tb/tb_fault_alert_ctrl.sv
`timescale 1ns/1ps
module tb_fault_alert_ctrl;
  localparam int unsigned FW = 48;
  localparam int unsigned WD_CYC = 20000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [FW-1:0] evt_i;
  logic          busy_evt_i, tmo_evt_i, latch_off_evt_i, out_en_i, pgood_i;
  logic          clr_i, mask_wr_i, ara_won_i;
  logic [7:0]    mask_sel_i, mask_val_i;
  logic [FW-1:0] stat_o;
  logic [7:0]    status_byte_o;
  logic [15:0]   status_word_o;
  logic          alert_n_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fault_alert_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .busy_evt_i(busy_evt_i),
    .tmo_evt_i(tmo_evt_i), .latch_off_evt_i(latch_off_evt_i),
    .out_en_i(out_en_i), .pgood_i(pgood_i), .clr_i(clr_i),
    .mask_wr_i(mask_wr_i), .mask_sel_i(mask_sel_i), .mask_val_i(mask_val_i),
    .ara_won_i(ara_won_i), .stat_o(stat_o), .status_byte_o(status_byte_o),
    .status_word_o(status_word_o), .alert_n_o(alert_n_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_evt(input int idx);
    evt_i[idx] = 1'b1;
    tick();
    evt_i = '0;
  endtask

  task automatic do_clear();
    clr_i = 1'b1;
    tick();
    clr_i = 1'b0;
  endtask

  task automatic mask_write(input logic [7:0] code, input logic [7:0] val);
    mask_wr_i = 1'b1; mask_sel_i = code; mask_val_i = val;
    tick();
    mask_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 stat after reset", 64'(stat_o), 64'h0);
    chk("R11 byte after reset", 64'(status_byte_o), 64'h0);
    chk("R11 word after reset", 64'(status_word_o), 64'h0);
    chk("R11 alert idle after reset", 64'(alert_n_o), 64'h1);
    pulse_evt(40);
    chk("R11 mfr mask zero, R6 alert", 64'(alert_n_o), 64'h0);
    do_clear();
  endtask

  task automatic t_sticky();
    pulse_evt(7);
    chk("R1 vout bit7 set", 64'(stat_o), 64'h80);
    chk("R6 alert on unmasked event", 64'(alert_n_o), 64'h0);
    tick(); tick(); tick();
    chk("R1 vout bit7 held", 64'(stat_o), 64'h80);
    do_clear();
    chk("R2 cleared", 64'(stat_o), 64'h0);
  endtask

  task automatic t_summary();
    evt_i[7] = 1; evt_i[15] = 1; evt_i[20] = 1; evt_i[24] = 1;
    evt_i[35] = 1; evt_i[42] = 1; busy_evt_i = 1;
    tick();
    evt_i = '0; busy_evt_i = 0;
    chk("R4 status byte", 64'(status_byte_o), 64'hBE);
    chk("R5 status word", 64'(status_word_o), 64'hF0BE);
    pgood_i = 1'b0;
    #1;
    chk("R5 power not good bit", 64'(status_word_o), 64'hF8BE);
    pgood_i = 1'b1;
    do_clear();
    chk("R2 busy cleared R4", 64'(status_byte_o), 64'h00);
    pulse_evt(0);
    chk("R4 vout non-ov bit leaves byte", 64'(status_byte_o), 64'h00);
    chk("R5 vout summary only", 64'(status_word_o), 64'h8000);
    do_clear();
  endtask

  task automatic t_clear_race();
    pulse_evt(8);
    evt_i[16] = 1'b1; clr_i = 1'b1;
    tick();
    evt_i = '0; clr_i = 1'b0;
    chk("R2 event wins over clear", 64'(stat_o), 64'h1 << 16);
    chk("R9 alert kept with race event", 64'(alert_n_o), 64'h0);
    do_clear();
  endtask

  task automatic t_mask();
    mask_write(8'h7B, 8'h01);
    pulse_evt(8);
    chk("R7 masked bit still latched", 64'(stat_o), 64'h1 << 8);
    chk("R7 masked bit no alert", 64'(alert_n_o), 64'h1);
    pulse_evt(9);
    chk("R8 unmasked iout bit alerts", 64'(alert_n_o), 64'h0);
    do_clear();
    mask_write(8'h80, 8'h80);
    pulse_evt(47);
    chk("R8 code 0x80 masks mfr bit7", 64'(alert_n_o), 64'h1);
    chk("R7 mfr bit7 latched", 64'(stat_o), 64'h1 << 47);
    do_clear();
  endtask

  task automatic t_bad_code_and_timeout();
    mask_write(8'h7F, 8'hFF);
    pulse_evt(32);
    chk("R8 unknown code changes no mask", 64'(alert_n_o), 64'h0);
    do_clear();
    mask_write(8'h7E, 8'hFF);
    pulse_evt(32);
    chk("R8 code 0x7E masks cml", 64'(alert_n_o), 64'h1);
    do_clear();
    tmo_evt_i = 1'b1;
    tick();
    tmo_evt_i = 1'b0;
    chk("R10 timeout alert despite mask", 64'(alert_n_o), 64'h0);
    chk("R10 timeout sets cml bit1", 64'(stat_o), 64'h1 << 33);
    do_clear();
  endtask

  task automatic t_release();
    pulse_evt(0);
    ara_won_i = 1'b1;
    tick();
    ara_won_i = 1'b0;
    chk("R9 ara releases alert", 64'(alert_n_o), 64'h1);
    chk("R9 ara keeps status", 64'(stat_o), 64'h1);
    evt_i[1] = 1'b1; ara_won_i = 1'b1;
    tick();
    evt_i = '0; ara_won_i = 1'b0;
    chk("R9 event beats ara", 64'(alert_n_o), 64'h0);
    do_clear();
    chk("R9 clear releases alert", 64'(alert_n_o), 64'h1);
    chk("R2 clear empties status", 64'(stat_o), 64'h0);
  endtask

  task automatic t_off();
    out_en_i = 1'b0;
    #1;
    chk("R3 off when disabled", 64'(status_byte_o[6]), 64'h1);
    out_en_i = 1'b1;
    #1;
    chk("R3 on when enabled", 64'(status_byte_o[6]), 64'h0);
    latch_off_evt_i = 1'b1;
    tick();
    latch_off_evt_i = 1'b0;
    chk("R3 latched off", 64'(status_byte_o[6]), 64'h1);
    do_clear();
    chk("R3 clear keeps latched off", 64'(status_byte_o[6]), 64'h1);
  endtask

  initial begin
    rst_n = 0; evt_i = '0; busy_evt_i = 0; tmo_evt_i = 0; latch_off_evt_i = 0;
    out_en_i = 1; pgood_i = 1; clr_i = 0; mask_wr_i = 0; mask_sel_i = '0;
    mask_val_i = '0; ara_won_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_sticky();
    t_summary();
    t_clear_race();
    t_mask();
    t_bad_code_and_timeout();
    t_release();
    t_off();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(WD_CYC * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule